// File: doc/BRIEF.md
# Deferred-Fault Tagged Register File

This block is a general-purpose register file in which every register holds two tag bits next to its data. The first tag, the poison bit, records that a terminating fault was deferred. The second tag, the speculative bit, records that a speculative writer produced the value. With these tags a scheduler can hoist instructions above branches. A speculative instruction that hits a terminating fault does not trap at once. It marks its destination instead. The fault is reported only when a non-speculative instruction later consumes that register. Resumable faults, such as a page miss, are still reported at once, whatever the writer's speculative status.

The register file has two combinational read ports and one write port. Each read port returns data and both tags. The write port carries the result data, a speculative flag, a terminating-fault flag, a resumable-fault flag and a link flag. The link flag says that the result belongs to the consumer that read its sources in the previous cycle. When that consumer was speculative and one of its used sources was poisoned, the poison carries over to its destination. A separate command port sets or clears the poison bit of one register. Reads are write-first, so a read returns the contents the register will hold after the current edge. Register 0 is hard-wired to zero.

Top module: `poison_regfile`

## Requirements
- R1: While reset is held low, and at its release, every register reads as data 0 with the poison and speculative bits both clear.
- R2: A write with both fault flags clear stores the data, clears the poison bit and copies the writer's speculative flag into the speculative bit.
- R3: A speculative write with the terminating-fault flag set stores its data, sets the poison bit and the speculative bit, and leaves immFault low in the next cycle.
- R4: A write with the resumable-fault flag set leaves the register unchanged and raises immFault in the next cycle, for speculative and non-speculative writers alike.
- R5: A non-speculative write with the terminating-fault flag set, and no resumable flag, leaves the register unchanged and raises immFault in the next cycle.
- R6: When a non-speculative consumer (useValid=1, useSpec=0) uses a port (useA or useB = 1) whose read returns poison=1, poisonFault is high in the next cycle. A poisoned register on a port that is not used raises nothing.
- R7: A speculative consumer that uses a poisoned source raises no poisonFault. A linked write (wrLinked=1) in the very next cycle sets the destination's poison bit. After a clean speculative use, a linked write leaves the poison bit clear.
- R8: cmdSet sets and cmdClr clears the poison bit of register cmdAddr. With both asserted, set wins. Against a write to the same register in the same cycle, the command decides the poison bit while the write still stores its data.
- R9: A read of the register being written or commanded in the same cycle returns the new data and tags (write-first).
- R10: Register 0 always reads data 0 with both tags clear. Writes and commands aimed at it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write port valid |
| wrAddr | input | ADDR_W | Destination register |
| wrData | input | DATA_W | Result data |
| wrSpec | input | 1 | Writer is speculative |
| wrTermFault | input | 1 | Writer suffered a terminating fault |
| wrResumable | input | 1 | Writer suffered a resumable fault |
| wrLinked | input | 1 | Result belongs to last cycle's consumer |
| cmdSet | input | 1 | Set poison of cmdAddr |
| cmdClr | input | 1 | Clear poison of cmdAddr |
| cmdAddr | input | ADDR_W | Poison command target |
| rdAddrA | input | ADDR_W | Read port A address |
| rdAddrB | input | ADDR_W | Read port B address |
| useValid | input | 1 | A consumer is issuing this cycle |
| useSpec | input | 1 | The consumer is speculative |
| useA | input | 1 | Consumer uses port A |
| useB | input | 1 | Consumer uses port B |
| rdDataA | output | DATA_W | Port A data |
| rdPoisonA | output | 1 | Port A poison tag |
| rdSpecA | output | 1 | Port A speculative tag |
| rdDataB | output | DATA_W | Port B data |
| rdPoisonB | output | 1 | Port B poison tag |
| rdSpecB | output | 1 | Port B speculative tag |
| poisonFault | output | 1 | Poisoned source consumed non-speculatively (registered) |
| immFault | output | 1 | Fault reported at once (registered) |

## Verification
The bench aims at the boundaries between deferred and immediate faults. A design that traps a speculative terminating fault at once would pulse immFault. A design that drops resumable faults from speculative writers, or lets faulting writes change the register, would show a missing pulse or corrupted contents. A poisoned register sits on a port that is not used, to catch a design that faults on every read and not on every use. Linked writes after poisoned and clean speculative uses catch poison that is lost or poison that is invented. Same-cycle write and command collisions, set-against-clear, bypass reads, and writes and commands to register 0 expose priority mistakes and a read-first bypass.

// File: rtl/prf_pkg.sv
package prf_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic we;         // commit write port to storage
    logic specTag;    // speculative tag to store
    logic poisonTag;  // poison tag to store with the write
    logic setPoison;  // force poison of cmdAddr high
    logic clrPoison;  // force poison of cmdAddr low
  } prfStrobe_t;

endpackage

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  prfStrobe_t        stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdPoisonA,
  output logic              rdSpecA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisonB,
  output logic              rdSpecB
);

  logic [DATA_W-1:0] dataQ      [NUM_REGS];
  logic              poisonQ    [NUM_REGS];
  logic              specQ      [NUM_REGS];
  logic [DATA_W-1:0] dataNext   [NUM_REGS];
  logic              poisonNext [NUM_REGS];
  logic              specNext   [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    if (g == 0) begin : gZero
      // hard-wired zero register
      assign dataQ[g]      = '0;
      assign poisonQ[g]    = 1'b0;
      assign specQ[g]      = 1'b0;
      assign dataNext[g]   = '0;
      assign poisonNext[g] = 1'b0;
      assign specNext[g]   = 1'b0;
    end else begin : gLive
      logic wrHit;
      logic setHit;
      logic clrHit;
      logic poisonAfterWr;

      assign wrHit  = stb.we && (wrAddr == ADDR_W'(g));
      assign setHit = stb.setPoison && (cmdAddr == ADDR_W'(g));
      assign clrHit = stb.clrPoison && (cmdAddr == ADDR_W'(g));

      assign poisonAfterWr = wrHit ? stb.poisonTag : poisonQ[g];
      assign dataNext[g]   = wrHit ? wrData : dataQ[g];
      assign specNext[g]   = wrHit ? stb.specTag : specQ[g];
      // command decides the poison bit; set beats clear
      assign poisonNext[g] = setHit ? 1'b1 : (clrHit ? 1'b0 : poisonAfterWr);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataQ[g]   <= '0;
          poisonQ[g] <= 1'b0;
          specQ[g]   <= 1'b0;
        end else begin
          dataQ[g]   <= dataNext[g];
          poisonQ[g] <= poisonNext[g];
          specQ[g]   <= specNext[g];
        end
      end
    end
  end

  // Write-first reads: show what the register holds after this edge
  assign rdDataA   = dataNext[rdAddrA];
  assign rdPoisonA = poisonNext[rdAddrA];
  assign rdSpecA   = specNext[rdAddrA];
  assign rdDataB   = dataNext[rdAddrB];
  assign rdPoisonB = poisonNext[rdAddrB];
  assign rdSpecB   = specNext[rdAddrB];

  // R2: a clean write leaves the poison bit clear unless a set command overrides it
  p_clean_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.we && !stb.poisonTag && !(stb.setPoison && cmdAddr == wrAddr))
      |=> !poisonQ[$past(wrAddr)]);

  // R3: a deferred terminating fault leaves the destination poisoned
  p_defer_poison_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.we && stb.poisonTag && !(stb.clrPoison && !stb.setPoison && cmdAddr == wrAddr))
      |=> poisonQ[$past(wrAddr)]);

  // R8: the set command always wins
  p_set_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setPoison |=> poisonQ[$past(cmdAddr)]);

  // R10: control never commits a write to register 0
  p_no_zero_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.we && wrAddr == '0));

endmodule

// File: rtl/prf_control.sv
module prf_control
  import prf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrSpec,
  input  logic              wrTermFault,
  input  logic              wrResumable,
  input  logic              wrLinked,
  input  logic              cmdSet,
  input  logic              cmdClr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              useValid,
  input  logic              useSpec,
  input  logic              useA,
  input  logic              useB,
  input  logic              rdPoisonA,
  input  logic              rdPoisonB,
  output prfStrobe_t        stb,
  output logic              poisonFault,
  output logic              immFault
);

  logic srcPoisoned;
  logic carryQ;
  logic trapNow;
  logic notZeroWr;
  logic notZeroCmd;

  assign srcPoisoned = useValid && ((useA && rdPoisonA) || (useB && rdPoisonB));
  // faults that cannot be deferred: resumable, or terminating without speculation
  assign trapNow    = wrEn && (wrResumable || (wrTermFault && !wrSpec));
  assign notZeroWr  = (wrAddr != '0);
  assign notZeroCmd = (cmdAddr != '0);

  always_comb begin
    stb.we        = wrEn && !trapNow && notZeroWr;
    stb.specTag   = wrSpec;
    stb.poisonTag = (wrTermFault && wrSpec) || (wrLinked && carryQ);
    stb.setPoison = cmdSet && notZeroCmd;
    stb.clrPoison = cmdClr && notZeroCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ      <= 1'b0;
      poisonFault <= 1'b0;
      immFault    <= 1'b0;
    end else begin
      carryQ      <= srcPoisoned && useSpec;
      poisonFault <= srcPoisoned && !useSpec;
      immFault    <= trapNow;
    end
  end

  // R6: a non-speculative use of a poisoned port faults one cycle later
  p_consume_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (useValid && !useSpec && ((useA && rdPoisonA) || (useB && rdPoisonB)))
      |=> poisonFault);

  // R7: speculative consumers never fault
  p_spec_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (useValid && useSpec) |=> !poisonFault);

  // R7: poison carried to the linked write that follows
  p_carry_poison_r7: assert property (@(posedge clk) disable iff (!rstN)
    (useValid && useSpec && ((useA && rdPoisonA) || (useB && rdPoisonB)))
      |=> (!(wrEn && wrLinked) || stb.poisonTag));

  // R4: resumable faults are reported regardless of speculation
  p_resumable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrResumable) |=> immFault);

  // R3: speculative terminating faults are deferred silently
  p_deferred_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSpec && wrTermFault && !wrResumable) |=> !immFault);

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import prf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSpec,
  input  logic              wrTermFault,
  input  logic              wrResumable,
  input  logic              wrLinked,
  input  logic              cmdSet,
  input  logic              cmdClr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              useValid,
  input  logic              useSpec,
  input  logic              useA,
  input  logic              useB,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdPoisonA,
  output logic              rdSpecA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisonB,
  output logic              rdSpecB,
  output logic              poisonFault,
  output logic              immFault
);

  prfStrobe_t stb;

  prf_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSpec(wrSpec),
    .wrTermFault(wrTermFault), .wrResumable(wrResumable), .wrLinked(wrLinked),
    .cmdSet(cmdSet), .cmdClr(cmdClr), .cmdAddr(cmdAddr),
    .useValid(useValid), .useSpec(useSpec), .useA(useA), .useB(useB),
    .rdPoisonA(rdPoisonA), .rdPoisonB(rdPoisonB),
    .stb(stb), .poisonFault(poisonFault), .immFault(immFault)
  );

  prf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .cmdAddr(cmdAddr),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdPoisonA(rdPoisonA), .rdSpecA(rdSpecA),
    .rdDataB(rdDataB), .rdPoisonB(rdPoisonB), .rdSpecB(rdSpecB)
  );

endmodule

// File: tb/sim_poison_regfile.sv
`timescale 1ns/100ps
module sim_poison_regfile;
  localparam int NR = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic wrEn, wrSpec, wrTermFault, wrResumable, wrLinked;
  logic [AW-1:0] wrAddr, cmdAddr, rdAddrA, rdAddrB;
  logic [DW-1:0] wrData;
  logic cmdSet, cmdClr, useValid, useSpec, useA, useB;
  logic [DW-1:0] rdDataA, rdDataB;
  logic rdPoisonA, rdSpecA, rdPoisonB, rdSpecB, poisonFault, immFault;

  poison_regfile #(.NUM_REGS(NR), .DATA_W(DW)) u0 (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic [3:0]    req;
    logic          wen;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;
    logic          wspec;
    logic          wterm;
    logic          wres;
    logic [AW-1:0] raddr;
    logic [DW-1:0] expData;
    logic          expPoison;
    logic          expSpec;
    logic          expImm;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R9 + R2: clean write, bypass read
    '{4'd9, 1'b1, 4'd3, 32'hA5A50003, 1'b0, 1'b0, 1'b0, 4'd3, 32'hA5A50003, 1'b0, 1'b0, 1'b0},
    // R2: speculative clean write sets spec tag
    '{4'd2, 1'b1, 4'd4, 32'h00000044, 1'b1, 1'b0, 1'b0, 4'd4, 32'h00000044, 1'b0, 1'b1, 1'b0},
    // R2: stored value read back
    '{4'd2, 1'b0, 4'd0, 32'h0,        1'b0, 1'b0, 1'b0, 4'd3, 32'hA5A50003, 1'b0, 1'b0, 1'b0},
    // R3: speculative terminating fault is deferred
    '{4'd3, 1'b1, 4'd5, 32'h0000DEAD, 1'b1, 1'b1, 1'b0, 4'd5, 32'h0000DEAD, 1'b1, 1'b1, 1'b0},
    // R4: speculative resumable fault reported, register kept
    '{4'd4, 1'b1, 4'd3, 32'h00001111, 1'b1, 1'b0, 1'b1, 4'd3, 32'hA5A50003, 1'b0, 1'b0, 1'b1},
    // R5: non-speculative terminating fault reported, register kept
    '{4'd5, 1'b1, 4'd4, 32'h00002222, 1'b0, 1'b1, 1'b0, 4'd4, 32'h00000044, 1'b0, 1'b1, 1'b1},
    // R10: write to register 0 ignored
    '{4'd10, 1'b1, 4'd0, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0,       1'b0, 1'b0, 1'b0},
    // R2: clean write clears poison left by R3 row
    '{4'd2, 1'b1, 4'd5, 32'h00000055, 1'b0, 1'b0, 1'b0, 4'd5, 32'h00000055, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrAddr = '0; wrData = '0; wrSpec = 0; wrTermFault = 0;
    wrResumable = 0; wrLinked = 0; cmdSet = 0; cmdClr = 0; cmdAddr = '0;
    rdAddrA = '0; rdAddrB = '0; useValid = 0; useSpec = 0; useA = 0; useB = 0;
  endtask

  // advance one edge; inputs may change right after
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    idle();
    rstN = 1'b0;
    tick(); tick();
    // R1: contents during reset
    rdAddrA = 4'd7; #0.5;
    chk("R1 data during reset", rdDataA, '0);
    rstN = 1'b1;
    for (int r = 0; r < NR; r++) begin
      rdAddrA = AW'(r); rdAddrB = AW'(r); #0.5;
      chk("R1 data A after reset", rdDataA, '0);
      chk("R1 tags A after reset", {30'd0, rdPoisonA, rdSpecA}, '0);
      chk("R1 tags B after reset", {30'd0, rdPoisonB, rdSpecB}, '0);
    end
    chk("R1 faults after reset", {30'd0, poisonFault, immFault}, '0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      idle();
      wrEn = VEC[i].wen; wrAddr = VEC[i].waddr; wrData = VEC[i].wdata;
      wrSpec = VEC[i].wspec; wrTermFault = VEC[i].wterm; wrResumable = VEC[i].wres;
      rdAddrA = VEC[i].raddr;
      #0.5;
      chk($sformatf("R%0d vec%0d data", VEC[i].req, i), rdDataA, VEC[i].expData);
      chk($sformatf("R%0d vec%0d poison", VEC[i].req, i), 32'(rdPoisonA), 32'(VEC[i].expPoison));
      chk($sformatf("R%0d vec%0d spec", VEC[i].req, i), 32'(rdSpecA), 32'(VEC[i].expSpec));
      tick();
      chk($sformatf("R%0d vec%0d immFault", VEC[i].req, i), 32'(immFault), 32'(VEC[i].expImm));
      chk($sformatf("R%0d vec%0d poisonFault", VEC[i].req, i), 32'(poisonFault), 32'd0);
    end

    // R3: poison register 6 silently
    idle(); wrEn = 1; wrAddr = 4'd6; wrData = 32'h66; wrSpec = 1; wrTermFault = 1;
    tick();
    chk("R3 no immFault", 32'(immFault), 32'd0);

    // R6: non-speculative use on port A
    idle(); useValid = 1; useA = 1; rdAddrA = 4'd6; #0.5;
    chk("R6 poison visible", 32'(rdPoisonA), 32'd1);
    tick();
    chk("R6 fault via port A", 32'(poisonFault), 32'd1);
    // R6: use on port B
    idle(); useValid = 1; useB = 1; rdAddrB = 4'd6;
    tick();
    chk("R6 fault via port B", 32'(poisonFault), 32'd1);
    // R6: poisoned register on unused port
    idle(); useValid = 1; useB = 1; rdAddrA = 4'd6; rdAddrB = 4'd3;
    tick();
    chk("R6 unused port quiet", 32'(poisonFault), 32'd0);

    // R7: speculative use propagates to linked write
    idle(); useValid = 1; useSpec = 1; useA = 1; rdAddrA = 4'd6;
    tick();
    chk("R7 spec use quiet", 32'(poisonFault), 32'd0);
    idle(); wrEn = 1; wrAddr = 4'd7; wrData = 32'h77; wrSpec = 1; wrLinked = 1; rdAddrA = 4'd7; #0.5;
    chk("R7 linked poison", 32'(rdPoisonA), 32'd1);
    chk("R9 linked data bypass", rdDataA, 32'h77);
    tick();
    // R7: clean speculative use, linked write stays clean
    idle(); useValid = 1; useSpec = 1; useA = 1; rdAddrA = 4'd5;
    tick();
    idle(); wrEn = 1; wrAddr = 4'd8; wrData = 32'h88; wrSpec = 1; wrLinked = 1;
    tick();
    idle(); rdAddrB = 4'd8; rdAddrA = 4'd7; #0.5;
    chk("R7 clean linked write", 32'(rdPoisonB), 32'd0);
    chk("R7 poison stored", 32'(rdPoisonA), 32'd1);

    // R8: commands
    idle(); cmdSet = 1; cmdAddr = 4'd9; rdAddrA = 4'd9; #0.5;
    chk("R8 set bypass", 32'(rdPoisonA), 32'd1);
    tick();
    idle(); cmdSet = 1; cmdClr = 1; cmdAddr = 4'd9;
    tick();
    idle(); rdAddrA = 4'd9; #0.5;
    chk("R8 set beats clear", 32'(rdPoisonA), 32'd1);
    cmdClr = 1; cmdAddr = 4'd9;
    tick();
    idle(); rdAddrA = 4'd9; #0.5;
    chk("R8 clear", 32'(rdPoisonA), 32'd0);
    wrEn = 1; wrAddr = 4'd9; wrData = 32'h99; cmdSet = 1; cmdAddr = 4'd9; #0.5;
    chk("R9 write and command bypass data", rdDataA, 32'h99);
    tick();
    idle(); rdAddrA = 4'd9; #0.5;
    chk("R8 command beats write", 32'(rdPoisonA), 32'd1);
    chk("R8 write data kept", rdDataA, 32'h99);
    // R10: command on register 0
    cmdSet = 1; cmdAddr = 4'd0; rdAddrB = 4'd0;
    tick();
    idle(); #0.5;
    chk("R10 zero reg tags", {30'd0, rdPoisonB, rdSpecB}, '0);

    // R1: reset in mid-run
    rstN = 1'b0;
    tick();
    rstN = 1'b1; rdAddrA = 4'd3; rdAddrB = 4'd9; #0.5;
    chk("R1 data cleared", rdDataA, '0);
    chk("R1 poison cleared", 32'(rdPoisonB), 32'd0);

    finishRun();
  end

endmodule